// File: doc/BRIEF.md
# CCD Horizontal Line Readout Sequencer

This block produces the horizontal timing for reading one line out of a CCD output register once the vertical shift into that register has completed. A one-cycle start strobe launches a line of fixed length, measured in pixel periods. Each pixel period is split into six clock cycles (subphases). From these subphases the block derives the three-phase register clocks, a reset-gate pulse, a summing-gate drive, a black-clamp window, a valid flag for active pixels and a tag that names the region the current cell belongs to. A one-cycle done strobe marks the end of the line.

Two mode inputs are captured when a line starts. The split input selects readout through two opposite outputs at once. In that mode each output carries the same leading region order and only half of the active width, so the register stops shifting earlier. The binning input merges each pair of neighbouring cells on the summing gate, which halves the number of reset pulses and valid samples. The default parameters describe a sensor line of 7 dummy, 20 black, 4 timing, 3072 active, 4 timing and 20 black cells inside a 3487-period line. The bench uses a reduced geometry.

Top module: `ccd_hline_seq`

## Requirements
- R1: After reset, and whenever no line is running, all three register clocks, the reset gate, the summing gate, the clamp, the valid flag and the done strobe are low, and the region tag reads 0 (idle).
- R2: A line starts at the first clock edge where the start input is high while no line is running. The split and binning inputs are captured at that edge only. A start strobe or a mode change during a running line has no effect on that line.
- R3: A line occupies exactly 6*LINE_PIXELS clock cycles, starting with the cycle after the start edge. The done output is high for exactly the one cycle that follows the last of them.
- R4: Subphase s counts 0 to 5 within each pixel period. While a cell is being shifted, clock 1 is high in subphases 0-2, clock 2 in subphases 2-4 and clock 3 in subphases 4, 5 and 0. All three clocks are low in the periods after the last shifted cell.
- R5: Without split, with pixel period index p counted from 0 at the start of the line, the region tag reads dummy=1, black=2, timing=3, active=4, timing=3, black=2 in runs of N_DUMMY, N_BLACK, N_TIMING, N_ACTIVE, N_TIMING and N_BLACK periods. It reads overhead=5 for the remaining periods.
- R6: With split, the tag runs dummy, black, timing and then active for N_ACTIVE/2 periods only. After that the register stops shifting and the tag reads overhead=5.
- R7: The reset gate is high in subphase 0 of each shifted period. With binning it is high only in even-indexed periods.
- R8: The summing gate is high in subphases 0-2 of each shifted period. With binning it stays high for the whole of each even period and for subphases 0-2 of the following odd period, so it falls once per pair of cells.
- R9: The clamp is high exactly in periods tagged black. The valid flag is high exactly in periods tagged active, and with binning only in the odd periods among them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Subphase clock, six cycles per pixel period |
| rst | input | 1 | Synchronous active-high reset |
| line_start | input | 1 | Launch a line when idle |
| split_mode | input | 1 | Two-output readout, captured at line start |
| bin_mode | input | 1 | Horizontal pair binning, captured at line start |
| hclk | output | 3 | Register clocks, bit 0 is phase 1 |
| rst_gate | output | 1 | Sense-node reset pulse |
| sum_gate | output | 1 | Summing gate drive |
| black_clamp | output | 1 | Black-level clamp window |
| pix_valid | output | 1 | Sample is an active output pixel |
| region_tag | output | 3 | Region code of the current cell |
| line_done | output | 1 | One-cycle end-of-line strobe |

## Verification
Every cycle of whole lines is compared against an arithmetic model in all four combinations of split and binning. Single versus split shows whether the active run is cut at half width and whether shifting stops at the right cell. Binning versus plain separates the gating of the reset pulse, summing gate and valid flag on period parity. One line receives a second start strobe and flipped mode inputs halfway through, which shows that the captured mode and the running count are immune to them. Idle stretches before and after lines expose any output that leaks outside a line.

// File: rtl/ccd_hseq_pkg.sv
package ccd_hseq_pkg;

    localparam int SUBPHASES = 6;

    typedef enum logic [2:0] {
        RGN_IDLE     = 3'd0,
        RGN_DUMMY    = 3'd1,
        RGN_BLACK    = 3'd2,
        RGN_TIMING   = 3'd3,
        RGN_ACTIVE   = 3'd4,
        RGN_OVERHEAD = 3'd5
    } region_e;

    typedef struct packed {
        logic split;
        logic bin;
    } line_mode_t;

    // Number of cells shifted out per output in one line.
    function automatic int cells_shifted(logic split, int nd, int nb, int nt, int na);
        if (split)
            return nd + nb + nt + na / 2;
        return nd + 2 * nb + 2 * nt + na;
    endfunction

    // Region of pixel period p (p counted from zero at line start).
    function automatic region_e region_at(int p, logic split, int nd, int nb, int nt, int na);
        int edge_blk;
        int edge_tim;
        int edge_act;
        int edge_tim2;
        int edge_blk2;
        edge_blk  = nd;
        edge_tim  = edge_blk + nb;
        edge_act  = edge_tim + nt;
        edge_tim2 = edge_act + (split ? na / 2 : na);
        edge_blk2 = edge_tim2 + nt;
        if (p < edge_blk)  return RGN_DUMMY;
        if (p < edge_tim)  return RGN_BLACK;
        if (p < edge_act)  return RGN_TIMING;
        if (p < edge_tim2) return RGN_ACTIVE;
        if (split)         return RGN_OVERHEAD;
        if (p < edge_blk2) return RGN_TIMING;
        if (p < edge_blk2 + nb) return RGN_BLACK;
        return RGN_OVERHEAD;
    endfunction

endpackage

// File: rtl/hseq_timebase.sv
module hseq_timebase
    import ccd_hseq_pkg::*;
#(
    parameter int LINE_PIXELS = 3487,
    localparam int PIX_W = $clog2(LINE_PIXELS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  line_mode_t       mode_in,
    output logic             busy,
    output logic [2:0]       sub,
    output logic [PIX_W-1:0] pix,
    output line_mode_t       mode,
    output logic             done
);
    localparam logic [PIX_W-1:0] LAST_PIX = PIX_W'(LINE_PIXELS - 1);
    localparam logic [2:0]       LAST_SUB = 3'(SUBPHASES - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            sub  <= '0;
            pix  <= '0;
            mode <= '0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                if (start) begin
                    busy <= 1'b1;
                    sub  <= '0;
                    pix  <= '0;
                    mode <= mode_in;
                end
            end else if (sub == LAST_SUB) begin
                sub <= '0;
                if (pix == LAST_PIX) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end else begin
                    pix <= pix + 1'b1;
                end
            end else begin
                sub <= sub + 3'd1;
            end
        end
    end

    AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (busy && start && sub != LAST_SUB) |=> (sub == $past(sub) + 3'd1)); // R2
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R3
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy); // R3
endmodule

// File: rtl/hseq_region.sv
module hseq_region
    import ccd_hseq_pkg::*;
#(
    parameter int N_DUMMY  = 7,
    parameter int N_BLACK  = 20,
    parameter int N_TIMING = 4,
    parameter int N_ACTIVE = 3072,
    parameter int PIX_W    = 12
) (
    input  logic             busy,
    input  logic [PIX_W-1:0] pix,
    input  logic             split,
    output region_e          region,
    output logic             shifting
);
    int pix_i;
    assign pix_i = int'(pix);

    always_comb begin
        if (!busy) begin
            region   = RGN_IDLE;
            shifting = 1'b0;
        end else begin
            region   = region_at(pix_i, split, N_DUMMY, N_BLACK, N_TIMING, N_ACTIVE);
            shifting = pix_i < cells_shifted(split, N_DUMMY, N_BLACK, N_TIMING, N_ACTIVE);
        end
    end
endmodule

// File: rtl/hseq_clkgen.sv
module hseq_clkgen
    import ccd_hseq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       shifting,
    input  logic [2:0] sub,
    input  logic       odd_pix,
    input  logic       bin,
    output logic [2:0] ph,
    output logic       rg,
    output logic       sg
);
    // Phase k is high for three subphases starting at subphase 2k.
    for (genvar k = 0; k < 3; k++) begin : g_phase
        localparam int START = 2 * k;
        int rel;
        always_comb begin
            rel   = (int'(sub) - START + SUBPHASES) % SUBPHASES;
            ph[k] = shifting && (rel < 3);
        end
    end

    logic first_half;
    assign first_half = (sub <= 3'd2);

    always_comb begin
        rg = shifting && (sub == 3'd0) && (!bin || !odd_pix);
        if (bin)
            sg = shifting && (!odd_pix || first_half);
        else
            sg = shifting && first_half;
    end

    AST_PHASE_COUNT: assert property (@(posedge clk) disable iff (rst)
        shifting |-> ($countones(ph) == 1 || $countones(ph) == 2)); // R4
    AST_RG_IN_OVERLAP: assert property (@(posedge clk) disable iff (rst)
        rg |-> (ph[0] && ph[2] && !ph[1])); // R7
endmodule

// File: rtl/ccd_hline_seq.sv
module ccd_hline_seq
    import ccd_hseq_pkg::*;
#(
    parameter int N_DUMMY     = 7,
    parameter int N_BLACK     = 20,
    parameter int N_TIMING    = 4,
    parameter int N_ACTIVE    = 3072,
    parameter int LINE_PIXELS = 3487
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       line_start,
    input  logic       split_mode,
    input  logic       bin_mode,
    output logic [2:0] hclk,
    output logic       rst_gate,
    output logic       sum_gate,
    output logic       black_clamp,
    output logic       pix_valid,
    output logic [2:0] region_tag,
    output logic       line_done
);
    localparam int PIX_W = $clog2(LINE_PIXELS);

    logic             busy;
    logic [2:0]       sub;
    logic [PIX_W-1:0] pix;
    line_mode_t       mode_in;
    line_mode_t       mode;
    region_e          region;
    logic             shifting;

    assign mode_in = '{split: split_mode, bin: bin_mode};

    hseq_timebase #(.LINE_PIXELS(LINE_PIXELS)) i_timebase (
        .clk(clk), .rst(rst), .start(line_start), .mode_in(mode_in),
        .busy(busy), .sub(sub), .pix(pix), .mode(mode), .done(line_done)
    );

    hseq_region #(
        .N_DUMMY(N_DUMMY), .N_BLACK(N_BLACK), .N_TIMING(N_TIMING),
        .N_ACTIVE(N_ACTIVE), .PIX_W(PIX_W)
    ) i_region (
        .busy(busy), .pix(pix), .split(mode.split),
        .region(region), .shifting(shifting)
    );

    hseq_clkgen i_clkgen (
        .clk(clk), .rst(rst), .shifting(shifting), .sub(sub),
        .odd_pix(pix[0]), .bin(mode.bin),
        .ph(hclk), .rg(rst_gate), .sg(sum_gate)
    );

    assign region_tag  = region;
    assign black_clamp = (region == RGN_BLACK);
    assign pix_valid   = (region == RGN_ACTIVE) && (!mode.bin || pix[0]);

    AST_VALID_NOT_CLAMP: assert property (@(posedge clk) disable iff (rst)
        pix_valid |-> !black_clamp); // R9
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (region_tag == 3'd0) |-> (hclk == 3'b000 && !rst_gate && !sum_gate && !pix_valid)); // R1
    AST_DONE_ENDS_LINE: assert property (@(posedge clk) disable iff (rst)
        line_done |-> (region_tag == 3'd0)); // R3
endmodule

// File: tb/test_ccd_hline_seq.sv
module test_ccd_hline_seq;
    localparam int ND = 2, NB = 3, NT = 1, NA = 8, NL = 40;
    localparam int CYC = 6 * NL;

    logic clk = 1'b0;
    logic rst, line_start, split_mode, bin_mode;
    logic [2:0] hclk, region_tag;
    logic rst_gate, sum_gate, black_clamp, pix_valid, line_done;
    int n_checks = 0, n_errors = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    ccd_hline_seq #(
        .N_DUMMY(ND), .N_BLACK(NB), .N_TIMING(NT), .N_ACTIVE(NA), .LINE_PIXELS(NL)
    ) i_ccd_hline_seq (
        .clk(clk), .rst(rst), .line_start(line_start), .split_mode(split_mode),
        .bin_mode(bin_mode), .hclk(hclk), .rst_gate(rst_gate), .sum_gate(sum_gate),
        .black_clamp(black_clamp), .pix_valid(pix_valid), .region_tag(region_tag),
        .line_done(line_done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int exp_region(int p, bit sp);
        int a_end;
        a_end = ND + NB + NT + (sp ? NA / 2 : NA);
        if (p < ND) return 1;
        if (p < ND + NB) return 2;
        if (p < ND + NB + NT) return 3;
        if (p < a_end) return 4;
        if (sp) return 5;
        if (p < a_end + NT) return 3;
        if (p < a_end + NT + NB) return 2;
        return 5;
    endfunction

    task automatic check_idle(input string req);
        chk(hclk == 3'b000 && !rst_gate && !sum_gate && !black_clamp && !pix_valid
            && region_tag == 3'd0, req, {hclk, rst_gate, sum_gate, black_clamp, pix_valid, region_tag}, 0);
    endtask

    task automatic run_line(input bit sp, input bit bn, input bit disturb);
        int cells;
        cells = sp ? (ND + NB + NT + NA / 2) : (ND + 2 * NB + 2 * NT + NA);
        @(negedge clk);
        split_mode = sp; bin_mode = bn; line_start = 1'b1;
        @(negedge clk);
        line_start = 1'b0;
        for (int j = 0; j < CYC; j++) begin
            int p, s, rgn;
            bit sh, odd;
            logic [2:0] eph;
            bit erg, esg, epv;
            p = j / 6; s = j % 6; odd = p[0];
            sh = p < cells;
            rgn = exp_region(p, sp);
            eph[0] = sh && (s <= 2);
            eph[1] = sh && (s >= 2 && s <= 4);
            eph[2] = sh && (s >= 4 || s == 0);
            erg = sh && s == 0 && (!bn || !odd);
            esg = sh && (bn ? (!odd || s <= 2) : (s <= 2));
            epv = (rgn == 4) && (!bn || odd);
            chk(hclk == eph, "R4 clocks", int'(hclk), int'(eph));
            chk(int'(region_tag) == rgn, sp ? "R6 split region" : "R5 region", int'(region_tag), rgn);
            chk(rst_gate == erg, "R7 reset gate", int'(rst_gate), int'(erg));
            chk(sum_gate == esg, "R8 summing gate", int'(sum_gate), int'(esg));
            chk(black_clamp == (rgn == 2), "R9 clamp", int'(black_clamp), int'(rgn == 2));
            chk(pix_valid == epv, "R9 valid", int'(pix_valid), int'(epv));
            chk(!line_done, "R3 no early done", int'(line_done), 0);
            if (disturb && j == 50) begin
                line_start = 1'b1; split_mode = ~sp; bin_mode = ~bn;
            end
            if (disturb && j == 51) line_start = 1'b0;
            if (disturb && j == 52)
                chk(int'(region_tag) == rgn, "R2 mid-line start ignored", int'(region_tag), rgn);
            @(negedge clk);
        end
        chk(line_done == 1'b1, "R3 done pulse", int'(line_done), 1);
        check_idle("R1 idle after line");
        @(negedge clk);
        chk(line_done == 1'b0, "R3 done single cycle", int'(line_done), 0);
        check_idle("R1 idle gap");
    endtask

    initial begin
        rst = 1'b1; line_start = 1'b0; split_mode = 1'b1; bin_mode = 1'b1;
        repeat (3) @(negedge clk);
        check_idle("R1 in reset");
        chk(!line_done, "R1 done in reset", int'(line_done), 0);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        check_idle("R1 idle without start");
        run_line(1'b0, 1'b0, 1'b0);
        run_line(1'b1, 1'b0, 1'b0);
        run_line(1'b0, 1'b1, 1'b0);
        run_line(1'b1, 1'b1, 1'b0);
        run_line(1'b0, 1'b1, 1'b1);
        run_line(1'b1, 1'b0, 1'b1);
        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end
endmodule